// File: doc/BRIEF.md
# Lockable Trace Buffer Readout Port

This block holds the entries that a debug logic captures while it is armed, and lets software read them back afterwards through one 16-bit register window. Each stored entry is 20 bits wide, so it is delivered as two word reads: the low half first, then the upper four bits. An internal read pointer steps forward on every read that the port accepts. The entries come out in the order they were captured, starting from the oldest one that survives.

The port guards the stored data. Arming the debugger locks the window and parks the read pointer on the oldest entry. Software must then disarm and make one aligned word write to the window before any read returns data. That write only opens the lock and leaves the stored entries as they were. Reads are refused in these cases: a byte-wide read, a read at the odd byte address, a read while armed, a read while the source enable is low, and a read while still locked. A refused read returns zero and leaves the pointer where it is. The storage has no reset, so a functional reset clears the pointers and the lock but keeps the captured entries.

Top module: `trace_window`

## Requirements
- R1: After reset the read data output is zero, the window is locked and the read pointer is on physical slot 0.
- R2: An accepted read (select, read strobe, byte address bit 0 low, both byte enables set, disarmed, source enabled, unlocked) returns bits 15:0 of the current entry on the first read. The second read returns bits 19:16 in bits 3:0, with bits 15:4 zero. Read data appears on the clock edge after the strobe.
- R3: Every accepted read moves the pointer on by one half-entry. Entries come back in capture order, and after the last slot (DEPTH-1) the pointer wraps to slot 0.
- R4: A read while the arm input is high returns zero and does not move the pointer.
- R5: A read while the source enable input is low returns zero and does not move the pointer.
- R6: A read with the byte enables other than 2'b11, or with byte address bit 0 high, returns zero and does not move the pointer.
- R7: While locked, reads return zero and do not move the pointer. Only a write with select, address bit 0 low and both byte enables set, made while disarmed, removes the lock. Such a write changes no stored entry. A byte write or a write while armed leaves the window locked.
- R8: The arm input being high locks the window again. A rise of arm restarts capture at slot 0. On disarm the pointer sits on the oldest entry: slot 0 if no more than DEPTH entries were captured, otherwise the slot after the newest entry.
- R9: Capture stores one entry per cycle when capture-valid and arm are both high. A capture-valid while disarmed stores nothing.
- R10: The reset input does not alter the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low functional reset (pointers, lock, read data) |
| arm_i | input | 1 | Debugger armed status |
| src_en_i | input | 1 | Trace source enable; reads are refused while low |
| cap_valid_i | input | 1 | Capture strobe, one entry per cycle |
| cap_data_i | input | EW (20) | Captured entry |
| bus_sel_i | input | 1 | Window selected by the bus |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr0_i | input | 1 | Byte address bit 0 (high = misaligned) |
| bus_be_i | input | 2 | Byte enables |
| bus_wdata_i | input | DW (16) | Write data, ignored apart from the unlock |
| bus_rdata_o | output | DW (16) | Read data, registered |

## Verification
Read data is registered, so the result of a read strobe that the clock edge samples is due on the next edge. The bench drives each strobe on a falling edge and compares the output on the following falling edge, one edge after the register loads. Capture, unlock and lock changes also take effect on the edge that samples them. The bench therefore checks their effect with a read issued afterwards and never in the same cycle. A refused read is followed by an accepted read whose expected value shows that the pointer did not move.

// File: rtl/trace_window.sv
module trace_window #(
  parameter int DEPTH = 64,
  parameter int EW    = 20,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          src_en_i,
  input  logic          cap_valid_i,
  input  logic [EW-1:0] cap_data_i,
  input  logic          bus_sel_i,
  input  logic          bus_rd_i,
  input  logic          bus_wr_i,
  input  logic          bus_addr0_i,
  input  logic [1:0]    bus_be_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int HW = EW - DW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_idx;
  logic          wrapped, rd_half, lock_q, arm_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i;

  // capture side
  logic          arm_rise, cap_go, wr_last, wrap_base, wrapped_n;
  logic [AW-1:0] wr_base, wr_n;

  assign arm_rise  = arm_i & ~arm_q;
  assign cap_go    = arm_i & cap_valid_i;
  assign wr_base   = arm_rise ? '0 : wr_ptr;
  assign wrap_base = arm_rise ? 1'b0 : wrapped;
  assign wr_last   = (wr_base == LAST);
  assign wr_n      = !cap_go ? wr_base : (wr_last ? '0 : wr_base + AW'(1));
  assign wrapped_n = wrap_base | (cap_go & wr_last);

  always_ff @(posedge clk) begin
    if (cap_go) mem[wr_base] <= cap_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      wr_ptr  <= wr_n;
      wrapped <= wrapped_n;
      arm_q   <= arm_i;
    end
  end

  // bus side
  logic          word_ok, rd_any, rd_ok, unlock;
  logic [EW-1:0] cur;
  logic [DW-1:0] rd_val;

  assign word_ok = bus_sel_i & ~bus_addr0_i & (bus_be_i == 2'b11);
  assign rd_any  = bus_sel_i & bus_rd_i;
  assign rd_ok   = rd_any & word_ok & ~arm_i & src_en_i & ~lock_q;
  assign unlock  = bus_wr_i & word_ok & ~arm_i;
  assign cur     = mem[rd_idx];
  assign rd_val  = rd_half ? {{(DW-HW){1'b0}}, cur[EW-1:DW]} : cur[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx      <= '0;
      rd_half     <= 1'b0;
      lock_q      <= 1'b1;
      bus_rdata_o <= '0;
    end else begin
      if (arm_i) begin
        rd_idx  <= wrapped_n ? wr_n : '0;
        rd_half <= 1'b0;
        lock_q  <= 1'b1;
      end else begin
        if (unlock) lock_q <= 1'b0;
        if (rd_ok) begin
          rd_half <= ~rd_half;
          if (rd_half) rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + AW'(1);
        end
      end
      if (rd_any) bus_rdata_o <= rd_ok ? rd_val : '0;
    end
  end

  // R4
  armed_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_rd_i && arm_i) |=> bus_rdata_o == '0);

  // R5
  srcoff_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_rd_i && !src_en_i && !arm_i)
      |=> (bus_rdata_o == '0) && $stable(rd_idx) && $stable(rd_half));

  // R6
  bad_access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_rd_i && (bus_addr0_i || bus_be_i != 2'b11) && !arm_i)
      |=> (bus_rdata_o == '0) && $stable(rd_idx) && $stable(rd_half));

  // R7
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(bus_sel_i && bus_wr_i && !bus_addr0_i
                            && bus_be_i == 2'b11 && !arm_i));

  // R8
  armed_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> lock_q);

  // R9
  idle_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !arm_q) |=> $stable(wr_ptr) && $stable(wrapped));

  // R3
  half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && rd_half && rd_idx == LAST) |=> (rd_idx == '0) && !rd_half);
endmodule

// File: tb/test_trace_window.sv
module test_trace_window;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, src_en = 1'b1, cap_valid = 1'b0;
  logic [19:0] cap_data = '0;
  logic        sel = 1'b0, rd = 1'b0, wr = 1'b0, addr0 = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0;

  logic [19:0] phys [DEPTH];
  int m_wptr = 0, m_idx = 0, m_half = 0;
  bit m_wrap = 0;

  always #4 clk = ~clk;

  trace_window #(.DEPTH(DEPTH)) i_trace_window (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .src_en_i(src_en),
    .cap_valid_i(cap_valid), .cap_data_i(cap_data),
    .bus_sel_i(sel), .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr0_i(addr0),
    .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata));

  function automatic logic [15:0] exp_word(int idx, int half);
    return half != 0 ? {12'h000, phys[idx][19:16]} : phys[idx][15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(bit a0, bit [1:0] b, bit se, output logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr0 = a0; be = b; src_en = se;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0; addr0 = 1'b0; be = 2'b00; src_en = 1'b1;
    d = rdata;
  endtask

  task automatic bus_write(bit a0, bit [1:0] b, logic [15:0] v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr0 = a0; be = b; wdata = v;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; addr0 = 1'b0; be = 2'b00;
  endtask

  task automatic good_read(string req);
    logic [15:0] d;
    bus_read(1'b0, 2'b11, 1'b1, d);
    check(req, d, exp_word(m_idx, m_half));
    if (m_half != 0) begin
      m_half = 0;
      m_idx  = (m_idx + 1) % DEPTH;
    end else m_half = 1;
  endtask

  task automatic refused_read(string req, bit a0, bit [1:0] b, bit se);
    logic [15:0] d;
    bus_read(a0, b, se, d);
    check(req, d, 16'h0000);
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1'b1;
    m_wptr = 0; m_wrap = 0;
  endtask

  task automatic do_disarm();
    @(negedge clk);
    arm = 1'b0;
    m_idx = m_wrap ? m_wptr : 0;
    m_half = 0;
  endtask

  task automatic capture(logic [19:0] v);
    @(negedge clk);
    cap_valid = 1'b1; cap_data = v;
    @(negedge clk);
    cap_valid = 1'b0;
    if (arm) begin
      phys[m_wptr] = v;
      if (m_wptr == DEPTH - 1) m_wrap = 1;
      m_wptr = (m_wptr + 1) % DEPTH;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int legal;
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rdata", rdata, 16'h0000);
    refused_read("R1 locked after reset", 1'b0, 2'b11, 1'b1);

    // run 1: ten entries
    do_arm();
    for (int i = 0; i < 10; i++) capture(20'($urandom));
    refused_read("R4 armed read", 1'b0, 2'b11, 1'b1);
    bus_write(1'b0, 2'b11, 16'hFFFF);
    do_disarm();
    refused_read("R7 armed write kept lock", 1'b0, 2'b11, 1'b1);
    bus_write(1'b0, 2'b01, 16'h1234);
    refused_read("R7 byte write kept lock", 1'b0, 2'b11, 1'b1);
    bus_write(1'b1, 2'b11, 16'h1234);
    refused_read("R7 odd write kept lock", 1'b0, 2'b11, 1'b1);
    bus_write(1'b0, 2'b11, 16'hFFFF);
    good_read("R2 low half first");
    refused_read("R5 source off", 1'b0, 2'b11, 1'b0);
    good_read("R2 high half after R5 hold");
    refused_read("R6 byte read", 1'b0, 2'b10, 1'b1);
    refused_read("R6 misaligned read", 1'b1, 2'b11, 1'b1);
    good_read("R6 pointer held");
    legal = 3;
    while (legal < 20) begin
      case ($urandom % 4)
        0: refused_read("R6 random byte", 1'b0, 2'($urandom % 3), 1'b1);
        1: refused_read("R6 random odd", 1'b1, 2'($urandom), 1'b1);
        2: refused_read("R5 random source off", 1'b0, 2'b11, 1'b0);
        default: begin good_read("R3 in-order readback"); legal++; end
      endcase
    end

    // run 2: overflow and wrap
    do_arm();
    for (int i = 0; i < 70; i++) capture(20'($urandom));
    do_disarm();
    capture(20'hABCDE);
    capture(20'h13579);
    bus_write(1'b0, 2'b11, 16'h0000);
    for (int i = 0; i < 2 * DEPTH + 2; i++) good_read("R8/R3/R9 oldest first and wrap");

    do_arm();
    do_disarm();
    refused_read("R8 relocked by arm", 1'b0, 2'b11, 1'b1);
    bus_write(1'b0, 2'b11, 16'h5A5A);
    good_read("R7 unlock left data");
    good_read("R7 unlock left data");

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_idx = 0; m_half = 0;
    check("R1 rdata after reset", rdata, 16'h0000);
    refused_read("R1 locked after reset", 1'b0, 2'b11, 1'b1);
    bus_write(1'b0, 2'b11, 16'hFFFF);
    for (int i = 0; i < 6; i++) good_read("R10 entries survive reset");
    summary();
  end
endmodule